// File: doc/BRIEF.md
# Scoreboard Dynamic-Scheduling Controller

This block is the central hazard bookkeeper of an out-of-order core that owns a small set of non-pipelined functional units. Decoded instructions arrive one at a time in program order. Each carries a unit selector, an operation code, one destination register and two source registers. The controller decides when each instruction may enter its unit (issue), when the unit may fetch its operands from the register file (operand read), and when the unit may put its result back (write-back). It produces only handshake and grant signals. The arithmetic, the register file contents and any datapath muxing sit outside.

Per unit, the block records the following: whether the unit is occupied, the operation, the target register, both source registers, the unit expected to produce each source, and a ready flag for each source. Per register, it records which unit, if any, will write it next. Values are never passed between units directly. A consumer waits until the producer has written the register file and then reads it there. A producer waits until every earlier reader of the old value has taken it.

Top module: `sb_ctrl`

## Requirements
- R1: After a synchronous reset, `rd_grant` and `wb_grant` are all zero and `iss_ready` is high.
- R2: `iss_fu` is the index (0 to 3) of the unit the instruction needs. An instruction is accepted on a rising edge where `iss_valid` and `iss_ready` are both high. `iss_ready` is low while the selected unit holds an instruction that has not written back.
- R3: `iss_ready` is low while the destination register is the target of an accepted instruction that has not written back. It rises in the cycle after that instruction's write-back grant.
- R4: Operands become available in the cycle after acceptance, unless a source is still pending. In that cycle `rd_grant[u]` is high for exactly one cycle, and `fu_op[4u+3:4u]` shows the accepted operation code.
- R5: If a source register has a pending producer when the instruction is accepted, `rd_grant` for the consumer stays low. It rises in the cycle after the producer's write-back grant.
- R6: A one-cycle `fu_done[u]` pulse, sent after the unit's operand read, makes that unit a write-back candidate from the next cycle on.
- R7: A candidate's write-back is held while another occupied unit has not yet read a source register equal to the candidate's destination. This covers a unit that is waiting for a different source. The hold is released in the cycle after that unit's read grant.
- R8: At most one bit of `wb_grant` is high. Among the eligible candidates, the lowest unit index wins. `wb_reg` shows the destination register of the granted unit.
- R9: A unit is free in the cycle after its write-back grant.
- R10: An instruction accepted in the same cycle as the write-back grant of its source's producer treats that source as ready. It gets `rd_grant` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_fu | input | 2 | Functional unit the instruction needs |
| iss_op | input | 4 | Operation code carried to the unit |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| iss_ready | output | 1 | The offered instruction may issue this cycle |
| rd_grant | output | 4 | Per unit: read operands from the register file now |
| fu_op | output | 16 | Per unit operation code, 4 bits each, unit 0 lowest |
| fu_done | input | 4 | Per unit: result is ready (one-cycle pulse) |
| wb_grant | output | 4 | One-hot: unit allowed to write its result now |
| wb_reg | output | 3 | Register written by the granted unit |

## Verification
The bench first stalls issue on a busy unit and on a pending destination. A controller that missed either check would accept a second instruction and corrupt the unit record or the register status. It then holds a consumer behind a producer and requires the read grant exactly one cycle after the producer's write-back. A wrong tag broadcast would leave the consumer hung or let it read early. A write-after-read case keeps a reader stalled on one source while it still needs the old value of another. A design that ignored that reader's ready flag would write back too soon. Two units that finish together must write back in index order. An issue that coincides with its producer's write-back must not be left waiting on a stale tag forever.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    parameter int unsigned FU_N  = 4;
    parameter int unsigned REG_N = 8;
    parameter int unsigned OP_W  = 4;

    localparam int unsigned FU_W  = $clog2(FU_N);
    localparam int unsigned REG_W = $clog2(REG_N);

    typedef logic [FU_W-1:0]  fu_id_t;
    typedef logic [REG_W-1:0] reg_id_t;
    typedef logic [OP_W-1:0]  op_t;

    // Producer reference: vld=0 means the value already sits in the register file
    typedef struct packed {
        logic   vld;
        fu_id_t id;
    } tag_t;

    // Full per-unit record held inside a slot
    typedef struct packed {
        logic    busy;
        op_t     op;
        reg_id_t fi;
        reg_id_t fj;
        reg_id_t fk;
        tag_t    qj;
        tag_t    qk;
        logic    rj;
        logic    rk;
        logic    fin;
    } fu_rec_t;

    // Fields of a slot that the surrounding control logic looks at
    typedef struct packed {
        logic    busy;
        op_t     op;
        reg_id_t fi;
        reg_id_t fj;
        reg_id_t fk;
        logic    rj;
        logic    rk;
        logic    fin;
    } fu_view_t;

    // A tag whose producer is writing back right now counts as resolved
    function automatic tag_t settle_tag(tag_t t, logic wb_any, fu_id_t wb_id);
        tag_t r;
        r = t;
        if (t.vld && wb_any && (t.id == wb_id))
            r = '0;
        return r;
    endfunction

    // Does this unit still need the old contents of register x?
    function automatic logic still_reads(fu_view_t v, reg_id_t x);
        return v.busy && ((v.rj && (v.fj == x)) || (v.rk && (v.fk == x)));
    endfunction

endpackage

// File: rtl/sbc_reg_status.sv
module sbc_reg_status
    import sbc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    set_en,
    input  reg_id_t set_reg,
    input  fu_id_t  set_fu,
    input  logic    clr_en,
    input  reg_id_t clr_reg,
    input  reg_id_t look_a,
    input  reg_id_t look_b,
    input  reg_id_t look_d,
    output tag_t    tag_a,
    output tag_t    tag_b,
    output logic    dst_pending
);

    tag_t tab [REG_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_N; i++)
                tab[i] <= '0;
        end else begin
            if (clr_en)
                tab[clr_reg] <= '0;
            if (set_en)
                tab[set_reg] <= '{vld: 1'b1, id: set_fu};
        end
    end

    assign tag_a       = tab[look_a];
    assign tag_b       = tab[look_b];
    assign dst_pending = tab[look_d].vld;

endmodule

// File: rtl/sbc_fu_slot.sv
module sbc_fu_slot
    import sbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     issue_en,
    input  op_t      iss_op,
    input  reg_id_t  iss_dst,
    input  reg_id_t  iss_src1,
    input  reg_id_t  iss_src2,
    input  tag_t     src1_tag,
    input  tag_t     src2_tag,
    input  logic     rd_take,
    input  logic     done_in,
    input  logic     wb_any,
    input  fu_id_t   wb_id,
    input  logic     wb_take,
    output fu_view_t view
);

    fu_rec_t r;

    always_ff @(posedge clk) begin
        if (rst) begin
            r <= '0;
        end else if (issue_en) begin
            r.busy <= 1'b1;
            r.op   <= iss_op;
            r.fi   <= iss_dst;
            r.fj   <= iss_src1;
            r.fk   <= iss_src2;
            r.qj   <= src1_tag;
            r.qk   <= src2_tag;
            r.rj   <= !src1_tag.vld;
            r.rk   <= !src2_tag.vld;
            r.fin  <= 1'b0;
        end else if (wb_take) begin
            r <= '0;
        end else begin
            // operands consumed: later WAR checks must see them as gone
            if (rd_take) begin
                r.rj <= 1'b0;
                r.rk <= 1'b0;
            end
            if (r.qj.vld && wb_any && (r.qj.id == wb_id)) begin
                r.qj <= '0;
                r.rj <= 1'b1;
            end
            if (r.qk.vld && wb_any && (r.qk.id == wb_id)) begin
                r.qk <= '0;
                r.rk <= 1'b1;
            end
            if (done_in && r.busy)
                r.fin <= 1'b1;
        end
    end

    assign view = '{busy: r.busy, op: r.op, fi: r.fi, fj: r.fj, fk: r.fk,
                    rj: r.rj, rk: r.rk, fin: r.fin};

endmodule

// File: rtl/sbc_wb_pick.sv
module sbc_wb_pick
    import sbc_pkg::*;
(
    input  logic [FU_N-1:0] elig,
    output logic [FU_N-1:0] grant,
    output logic            any,
    output fu_id_t          id
);

    assign grant = elig & (~elig + 1'b1);
    assign any   = |elig;

    always_comb begin
        id = '0;
        for (int i = FU_N - 1; i >= 0; i--)
            if (elig[i])
                id = fu_id_t'(i);
    end

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sbc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iss_valid,
    input  logic [FU_W-1:0]      iss_fu,
    input  logic [OP_W-1:0]      iss_op,
    input  logic [REG_W-1:0]     iss_dst,
    input  logic [REG_W-1:0]     iss_src1,
    input  logic [REG_W-1:0]     iss_src2,
    output logic                 iss_ready,
    output logic [FU_N-1:0]      rd_grant,
    output logic [FU_N*OP_W-1:0] fu_op,
    input  logic [FU_N-1:0]      fu_done,
    output logic [FU_N-1:0]      wb_grant,
    output logic [REG_W-1:0]     wb_reg
);

    fu_view_t        view [FU_N];
    tag_t            tag_a, tag_b, tag_a_eff, tag_b_eff;
    logic            dst_pending;
    logic            iss_take;
    logic [FU_N-1:0] elig;
    logic            wb_any;
    fu_id_t          wb_id;

    sbc_reg_status u_rstat (
        .clk        (clk),
        .rst        (rst),
        .set_en     (iss_take),
        .set_reg    (iss_dst),
        .set_fu     (iss_fu),
        .clr_en     (wb_any),
        .clr_reg    (wb_reg),
        .look_a     (iss_src1),
        .look_b     (iss_src2),
        .look_d     (iss_dst),
        .tag_a      (tag_a),
        .tag_b      (tag_b),
        .dst_pending(dst_pending)
    );

    assign tag_a_eff = settle_tag(tag_a, wb_any, wb_id);
    assign tag_b_eff = settle_tag(tag_b, wb_any, wb_id);

    assign iss_ready = !view[iss_fu].busy && !dst_pending;
    assign iss_take  = iss_valid && iss_ready;

    for (genvar f = 0; f < FU_N; f++) begin : g_fu
        logic war_ok;

        always_comb begin
            war_ok = 1'b1;
            for (int g = 0; g < FU_N; g++)
                if (g != f && still_reads(view[g], view[f].fi))
                    war_ok = 1'b0;
        end

        assign elig[f]               = view[f].busy && view[f].fin && war_ok;
        assign rd_grant[f]           = view[f].busy && view[f].rj && view[f].rk;
        assign fu_op[f*OP_W +: OP_W] = view[f].op;

        sbc_fu_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .issue_en(iss_take && (iss_fu == fu_id_t'(f))),
            .iss_op  (iss_op),
            .iss_dst (iss_dst),
            .iss_src1(iss_src1),
            .iss_src2(iss_src2),
            .src1_tag(tag_a_eff),
            .src2_tag(tag_b_eff),
            .rd_take (rd_grant[f]),
            .done_in (fu_done[f]),
            .wb_any  (wb_any),
            .wb_id   (wb_id),
            .wb_take (wb_grant[f]),
            .view    (view[f])
        );
    end

    sbc_wb_pick u_pick (
        .elig (elig),
        .grant(wb_grant),
        .any  (wb_any),
        .id   (wb_id)
    );

    assign wb_reg = wb_any ? view[wb_id].fi : '0;

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker
    import sbc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [FU_W-1:0]  iss_fu,
    input logic [REG_W-1:0] iss_dst,
    input logic [FU_N-1:0]  rd_grant,
    input logic [FU_N-1:0]  fu_done,
    input logic [FU_N-1:0]  wb_grant,
    input logic [REG_W-1:0] wb_reg
);

    logic [FU_N-1:0]  occ;
    logic [FU_N-1:0]  done_seen;
    logic [REG_N-1:0] pend;
    logic             take;

    assign take = iss_valid && iss_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ       <= '0;
            done_seen <= '0;
            pend      <= '0;
        end else begin
            for (int f = 0; f < FU_N; f++) begin
                if (wb_grant[f]) begin
                    occ[f]       <= 1'b0;
                    done_seen[f] <= 1'b0;
                end
                if (take && (iss_fu == fu_id_t'(f)))
                    occ[f] <= 1'b1;
                if (fu_done[f])
                    done_seen[f] <= 1'b1;
            end
            for (int r = 0; r < REG_N; r++) begin
                if ((wb_grant != '0) && (wb_reg == reg_id_t'(r)))
                    pend[r] <= 1'b0;
                if (take && (iss_dst == reg_id_t'(r)))
                    pend[r] <= 1'b1;
            end
        end
    end

    assert_issue_free_R2: assert property (@(posedge clk) disable iff (rst)
        take |-> !occ[iss_fu]);

    assert_no_waw_R3: assert property (@(posedge clk) disable iff (rst)
        take |-> !pend[iss_dst]);

    assert_one_wb_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_grant));

    assert_wb_reg_R8: assert property (@(posedge clk) disable iff (rst)
        (wb_grant != '0) |-> pend[wb_reg]);

    for (genvar f = 0; f < FU_N; f++) begin : g_chk
        assert_read_once_R4: assert property (@(posedge clk) disable iff (rst)
            rd_grant[f] |=> !rd_grant[f]);

        assert_read_busy_R4: assert property (@(posedge clk) disable iff (rst)
            rd_grant[f] |-> occ[f]);

        assert_wb_after_done_R6: assert property (@(posedge clk) disable iff (rst)
            wb_grant[f] |-> done_seen[f]);
    end

endmodule

bind sb_ctrl sbc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .iss_valid(iss_valid),
    .iss_ready(iss_ready),
    .iss_fu   (iss_fu),
    .iss_dst  (iss_dst),
    .rd_grant (rd_grant),
    .fu_done  (fu_done),
    .wb_grant (wb_grant),
    .wb_reg   (wb_reg)
);

// File: tb/sb_ctrl_test.sv
module sb_ctrl_test;
    import sbc_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 iss_valid = 1'b0;
    logic [FU_W-1:0]      iss_fu = '0;
    logic [OP_W-1:0]      iss_op = '0;
    logic [REG_W-1:0]     iss_dst = '0;
    logic [REG_W-1:0]     iss_src1 = '0;
    logic [REG_W-1:0]     iss_src2 = '0;
    logic                 iss_ready;
    logic [FU_N-1:0]      rd_grant;
    logic [FU_N*OP_W-1:0] fu_op;
    logic [FU_N-1:0]      fu_done = '0;
    logic [FU_N-1:0]      wb_grant;
    logic [REG_W-1:0]     wb_reg;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        int fu;
        int rg;
    } wb_exp_t;

    wb_exp_t exp_q [$];
    wb_exp_t got;

    always #5 clk = ~clk;

    sb_ctrl uut (
        .clk      (clk),
        .rst      (rst),
        .iss_valid(iss_valid),
        .iss_fu   (iss_fu),
        .iss_op   (iss_op),
        .iss_dst  (iss_dst),
        .iss_src1 (iss_src1),
        .iss_src2 (iss_src2),
        .iss_ready(iss_ready),
        .rd_grant (rd_grant),
        .fu_op    (fu_op),
        .fu_done  (fu_done),
        .wb_grant (wb_grant),
        .wb_reg   (wb_reg)
    );

    task automatic ck(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic edge_();
        @(posedge clk);
        #1;
    endtask

    task automatic present(input int fu, input int op, input int d, input int s1, input int s2);
        iss_valid = 1'b1;
        iss_fu    = FU_W'(fu);
        iss_op    = OP_W'(op);
        iss_dst   = REG_W'(d);
        iss_src1  = REG_W'(s1);
        iss_src2  = REG_W'(s2);
    endtask

    task automatic idle();
        iss_valid = 1'b0;
    endtask

    task automatic push(input int fu, input int rg);
        wb_exp_t e;
        e.fu = fu;
        e.rg = rg;
        exp_q.push_back(e);
    endtask

    // Monitor: each write-back grant must match the next expected item (R8)
    always @(negedge clk) begin
        if (!rst && (wb_grant != '0)) begin
            if (exp_q.size() == 0) begin
                ck("R8", "unexpected write-back grant", int'(wb_grant), 0);
            end else begin
                got = exp_q.pop_front();
                ck("R8", "write-back unit order", int'(wb_grant), 1 << got.fu);
                ck("R8", "write-back register", int'(wb_reg), got.rg);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        ck("R1", "rd_grant after reset", int'(rd_grant), 0);
        ck("R1", "wb_grant after reset", int'(wb_grant), 0);
        ck("R1", "iss_ready after reset", int'(iss_ready), 1);

        // Basic flow through unit 0, then reuse of the freed unit
        edge_(); present(0, 3, 1, 2, 3);
        @(negedge clk); ck("R2", "iss_ready free unit", int'(iss_ready), 1);
        edge_(); idle();
        @(negedge clk);
        ck("R4", "rd_grant after issue", int'(rd_grant), 1);
        ck("R4", "fu_op unit 0", int'(fu_op[OP_W-1:0]), 3);
        edge_();
        @(negedge clk);
        ck("R4", "rd_grant single pulse", int'(rd_grant), 0);
        ck("R6", "no write-back before done", int'(wb_grant), 0);
        edge_(); fu_done = 4'b0001;
        edge_(); fu_done = '0; push(0, 1); present(0, 5, 2, 0, 0);
        @(negedge clk);
        ck("R6", "wb_grant after done", int'(wb_grant), 1);
        ck("R2", "iss_ready busy unit", int'(iss_ready), 0);
        edge_();
        @(negedge clk); ck("R9", "unit free after write-back", int'(iss_ready), 1);
        edge_(); idle();
        @(negedge clk); ck("R9", "rd_grant on reused unit", int'(rd_grant), 1);
        edge_(); fu_done = 4'b0001;
        edge_(); fu_done = '0; push(0, 2);
        @(negedge clk); ck("R6", "second write-back", int'(wb_grant), 1);
        edge_();

        // RAW, structural and WAW stalls, then simultaneous finish
        edge_(); present(1, 1, 4, 0, 0);
        @(negedge clk); ck("R2", "issue unit 1", int'(iss_ready), 1);
        edge_(); present(2, 2, 5, 4, 0);
        @(negedge clk);
        ck("R4", "unit 1 reads", int'(rd_grant), 4'b0010);
        ck("R2", "issue unit 2", int'(iss_ready), 1);
        edge_(); present(1, 0, 6, 0, 0);
        @(negedge clk);
        ck("R2", "structural stall", int'(iss_ready), 0);
        ck("R5", "consumer held on RAW", int'(rd_grant), 0);
        edge_(); present(3, 0, 4, 0, 0); fu_done = 4'b0010;
        @(negedge clk); ck("R3", "WAW stall", int'(iss_ready), 0);
        edge_(); fu_done = '0; push(1, 4);
        @(negedge clk);
        ck("R6", "producer write-back", int'(wb_grant), 4'b0010);
        ck("R3", "WAW stall during write-back", int'(iss_ready), 0);
        edge_();
        @(negedge clk);
        ck("R5", "consumer reads after write-back", int'(rd_grant), 4'b0100);
        ck("R3", "WAW released", int'(iss_ready), 1);
        edge_(); idle();
        @(negedge clk); ck("R4", "unit 3 reads", int'(rd_grant), 4'b1000);
        edge_();
        edge_(); fu_done = 4'b1100;
        edge_(); fu_done = '0; push(2, 5);
        @(negedge clk); ck("R8", "lower index first", int'(wb_grant), 4'b0100);
        edge_(); push(3, 4);
        @(negedge clk); ck("R8", "higher index next", int'(wb_grant), 4'b1000);
        edge_();

        // WAR: unit 1 still needs old r3 while waiting on r1
        edge_(); present(0, 0, 1, 0, 0);
        edge_(); present(1, 0, 2, 3, 1);
        edge_(); present(2, 0, 3, 0, 0);
        edge_(); idle();
        @(negedge clk); ck("R5", "only unit 2 reads", int'(rd_grant), 4'b0100);
        edge_(); fu_done = 4'b0100;
        edge_(); fu_done = '0;
        @(negedge clk); ck("R7", "WAR hold", int'(wb_grant), 0);
        edge_();
        @(negedge clk);
        ck("R7", "WAR hold persists", int'(wb_grant), 0);
        ck("R5", "unit 1 still waits", int'(rd_grant), 0);
        edge_(); fu_done = 4'b0001;
        edge_(); fu_done = '0; push(0, 1);
        @(negedge clk); ck("R7", "blocked unit skipped", int'(wb_grant), 4'b0001);
        edge_();
        @(negedge clk);
        ck("R5", "unit 1 reads", int'(rd_grant), 4'b0010);
        ck("R7", "held until reader reads", int'(wb_grant), 0);
        edge_(); push(2, 3);
        @(negedge clk); ck("R7", "WAR released", int'(wb_grant), 4'b0100);
        edge_(); fu_done = 4'b0010;
        edge_(); fu_done = '0; push(1, 2);
        @(negedge clk); ck("R6", "unit 1 write-back", int'(wb_grant), 4'b0010);
        edge_();

        // R10: issue coinciding with producer write-back
        edge_(); present(0, 0, 7, 0, 0);
        edge_(); idle();
        edge_(); fu_done = 4'b0001;
        edge_(); fu_done = '0; push(0, 7); present(1, 0, 6, 7, 7);
        @(negedge clk);
        ck("R6", "producer write-back", int'(wb_grant), 4'b0001);
        ck("R10", "issue alongside write-back", int'(iss_ready), 1);
        edge_(); idle();
        @(negedge clk); ck("R10", "consumer reads next cycle", int'(rd_grant), 4'b0010);
        edge_(); fu_done = 4'b0010;
        edge_(); fu_done = '0; push(1, 6);
        @(negedge clk); ck("R6", "consumer write-back", int'(wb_grant), 4'b0010);
        edge_();
        repeat (3) edge_();
        @(negedge clk); ck("R8", "expected write-backs left", exp_q.size(), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule